// File: doc/BRIEF.md
# Message-Passing DMA Command Engine

This engine takes point-to-point message transfers off an embedded processor. The processor describes each message with four command writes. The engine queues the command and later carries it out with no further help from the processor. The processor's cost per message is therefore four writes, whatever the payload length.

For a send, the engine puts a header word on a streaming output and then streams the payload, which it reads word by word from a word-addressed memory port. For a receive, it waits for a packet on a streaming input. It checks the packet header against the command. It writes the payload into memory and then pulses a completion output, unless that command asked for no notification.

Commands of both directions share one queue and run strictly in the order they were posted. The memory read port has a fixed latency of one cycle.

Streaming rules: on both stream interfaces a beat moves on a rising edge where valid and ready are both high. Once the engine raises `tx_valid`, it holds `tx_valid` and `tx_data` unchanged until `tx_ready` is seen. The engine may stall for any number of cycles. `rx_ready` depends only on the engine's state and never on `rx_valid`, so the sender may wait for it before raising valid.

Top module: `msg_dma_engine`

## Requirements
- R1: A command is four `cmd_wr` beats on `cmd_data`, in this order: peer rank (low 8 bits), buffer address (low 16 bits), word count (low 8 bits), tag (low 8 bits). `cmd_is_recv` and `cmd_quiet` are sampled with the fourth beat.
- R2: A send emits one header word and then its payload. The header word is `{LOCAL_RANK[31:24], peer[23:16], tag[15:8], count[7:0]}`. The payload is the memory words at address, address+1, and so on, in that order.
- R3: The queue holds 8 commands. If the fourth beat arrives while the queue is full, that command is dropped and `ovf_err` rises. `ovf_err` stays high until reset.
- R4: Commands run one at a time in posting order, sends and receives alike. A send posted after a receive produces no stream output until that receive has completed.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values.
- R6: A receive accepts a header whose source field [31:24], tag field [15:8] and count field [7:0] all equal the command's peer, tag and count. Each payload beat is written to address+i.
- R7: A receive without the quiet flag pulses `done` high for exactly one cycle after it completes. This includes a zero-count receive, which completes right after its header. A quiet receive and a send never pulse `done`.
- R8: A header that fails the R6 match is consumed together with as many further beats as its own count field gives. None of these beats is written to memory. `mismatch_err` rises and stays high until reset, and the receive keeps waiting for a matching packet.
- R9: A send with a count of zero emits only its header word.
- R10: After reset, `tx_valid`, `rx_ready`, `done`, `ovf_err` and `mismatch_err` are low.
- R11: The engine samples `mem_rd_data` one cycle after `mem_rd_en`. A read and a write never happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command word strobe |
| cmd_data | input | 32 | Command word |
| cmd_is_recv | input | 1 | With the fourth word: 1 = receive, 0 = send |
| cmd_quiet | input | 1 | With the fourth word: suppress completion pulse |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory word address |
| mem_wr_data | output | 32 | Memory write data |
| mem_rd_data | input | 32 | Memory read data, one cycle after the request |
| tx_valid | output | 1 | Outgoing beat valid |
| tx_ready | input | 1 | Network accepts outgoing beat |
| tx_data | output | 32 | Outgoing beat |
| rx_valid | input | 1 | Incoming beat valid |
| rx_ready | output | 1 | Engine accepts incoming beat |
| rx_data | input | 32 | Incoming beat |
| done | output | 1 | One-cycle receive completion pulse |
| ovf_err | output | 1 | Sticky queue-overflow flag |
| mismatch_err | output | 1 | Sticky header-mismatch flag |

## Verification
A wrong word index in the assembler or a lost queue entry shows up at the next header on `tx_data`. There the fields or the tag order are wrong within a few cycles of dispatch. A bad payload counter shows up as a wrong address or an extra beat on the memory or stream ports in the very beam where it goes wrong. A missed return to the idle state stalls every later command, and the test of later traffic reveals it. A lost match decision surfaces as writes from a discarded packet, or as a missing `done` pulse, one cycle after the final beat.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  parameter int RANK_W = 8;
  parameter int TAG_W  = 8;
  parameter int LEN_W  = 8;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 32;
  parameter int CMD_WORDS = 4;

  typedef struct packed {
    logic              is_recv;
    logic              quiet;
    logic [RANK_W-1:0] peer;
    logic [ADDR_W-1:0] base;
    logic [LEN_W-1:0]  len;
    logic [TAG_W-1:0]  tag;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);

  // header field positions: count lowest, then tag, destination, source
  localparam int H_LEN_LSB = 0;
  localparam int H_TAG_LSB = LEN_W;
  localparam int H_DST_LSB = LEN_W + TAG_W;
  localparam int H_SRC_LSB = LEN_W + TAG_W + RANK_W;

  function automatic logic [DATA_W-1:0] make_hdr(
      logic [RANK_W-1:0] src, logic [RANK_W-1:0] dst,
      logic [TAG_W-1:0] tag, logic [LEN_W-1:0] len);
    logic [DATA_W-1:0] h;
    h = '0;
    h[H_SRC_LSB +: RANK_W] = src;
    h[H_DST_LSB +: RANK_W] = dst;
    h[H_TAG_LSB +: TAG_W]  = tag;
    h[H_LEN_LSB +: LEN_W]  = len;
    return h;
  endfunction
endpackage

// File: rtl/cmd_assembler.sv
module cmd_assembler
  import mpe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              is_recv,
  input  logic              quiet,
  input  logic              q_full,
  output logic              push,
  output cmd_t              push_cmd,
  output logic              ovf_err
);
  localparam int IDX_W = $clog2(CMD_WORDS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CMD_WORDS - 1);

  logic [IDX_W-1:0]  idx;
  logic [RANK_W-1:0] peer_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic              last_beat;

  assign last_beat = wr && (idx == LAST);
  assign push      = last_beat && !q_full;
  assign push_cmd  = '{is_recv: is_recv, quiet: quiet, peer: peer_q,
                       base: base_q, len: len_q, tag: wdata[TAG_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx     <= '0;
      peer_q  <= '0;
      base_q  <= '0;
      len_q   <= '0;
      ovf_err <= 1'b0;
    end else if (wr) begin
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
      case (idx)
        IDX_W'(0): peer_q <= wdata[RANK_W-1:0];
        IDX_W'(1): base_q <= wdata[ADDR_W-1:0];
        IDX_W'(2): len_q  <= wdata[LEN_W-1:0];
        default:   if (q_full) ovf_err <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cmd_queue.sv
module cmd_queue #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = store[rptr];

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) store[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import mpe_pkg::*;
#(
  parameter int LOCAL_RANK = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  cmd_t              q_head,
  output logic              q_pop,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              done,
  output logic              mismatch_err
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_THDR, ST_RD, ST_CAP, ST_TDAT, ST_RHDR, ST_RDAT, ST_DROP
  } state_t;

  state_t            state;
  cmd_t              cur;
  logic [LEN_W-1:0]  idx, drop_left;
  logic [DATA_W-1:0] tx_buf;
  logic              hdr_ok, last_word;
  logic [LEN_W-1:0]  rx_len;

  assign rx_len    = rx_data[H_LEN_LSB +: LEN_W];
  assign hdr_ok    = (rx_data[H_SRC_LSB +: RANK_W] == cur.peer) &&
                     (rx_data[H_TAG_LSB +: TAG_W] == cur.tag) &&
                     (rx_len == cur.len);
  assign last_word = (idx == cur.len - LEN_W'(1));

  assign q_pop       = (state == ST_IDLE) && !q_empty;
  assign tx_valid    = (state == ST_THDR) || (state == ST_TDAT);
  assign tx_data     = (state == ST_THDR)
                       ? make_hdr(RANK_W'(LOCAL_RANK), cur.peer, cur.tag, cur.len)
                       : tx_buf;
  assign mem_rd_en   = (state == ST_RD);
  assign rx_ready    = (state == ST_RHDR) || (state == ST_RDAT) || (state == ST_DROP);
  assign mem_wr_en   = (state == ST_RDAT) && rx_valid;
  assign mem_addr    = cur.base + ADDR_W'(idx);
  assign mem_wr_data = rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cur          <= '0;
      idx          <= '0;
      drop_left    <= '0;
      tx_buf       <= '0;
      done         <= 1'b0;
      mismatch_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (!q_empty) begin
          cur   <= q_head;
          idx   <= '0;
          state <= q_head.is_recv ? ST_RHDR : ST_THDR;
        end
        ST_THDR: if (tx_ready) state <= (cur.len == '0) ? ST_IDLE : ST_RD;
        ST_RD:   state <= ST_CAP;
        ST_CAP: begin
          tx_buf <= mem_rd_data;
          state  <= ST_TDAT;
        end
        ST_TDAT: if (tx_ready) begin
          if (last_word) state <= ST_IDLE;
          else begin
            idx   <= idx + 1'b1;
            state <= ST_RD;
          end
        end
        ST_RHDR: if (rx_valid) begin
          if (hdr_ok) begin
            if (cur.len == '0) begin
              done  <= !cur.quiet;
              state <= ST_IDLE;
            end else state <= ST_RDAT;
          end else begin
            mismatch_err <= 1'b1;
            drop_left    <= rx_len;
            if (rx_len != '0) state <= ST_DROP;
          end
        end
        ST_RDAT: if (rx_valid) begin
          if (last_word) begin
            done  <= !cur.quiet;
            state <= ST_IDLE;
          end else idx <= idx + 1'b1;
        end
        ST_DROP: if (rx_valid) begin
          drop_left <= drop_left - 1'b1;
          if (drop_left == LEN_W'(1)) state <= ST_RHDR;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msg_dma_engine.sv
module msg_dma_engine
  import mpe_pkg::*;
#(
  parameter int LOCAL_RANK  = 1,
  parameter int QUEUE_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_is_recv,
  input  logic              cmd_quiet,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              done,
  output logic              ovf_err,
  output logic              mismatch_err
);
  logic push, pop, q_empty, q_full;
  cmd_t push_cmd, head_cmd;

  cmd_assembler u_asm (
    .clk(clk), .rst_n(rst_n), .wr(cmd_wr), .wdata(cmd_data),
    .is_recv(cmd_is_recv), .quiet(cmd_quiet), .q_full(q_full),
    .push(push), .push_cmd(push_cmd), .ovf_err(ovf_err)
  );

  cmd_queue #(.WIDTH(CMD_W), .DEPTH(QUEUE_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_cmd),
    .pop(pop), .head(head_cmd), .empty(q_empty), .full(q_full)
  );

  xfer_engine #(.LOCAL_RANK(LOCAL_RANK)) u_xfer (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_head(head_cmd), .q_pop(pop),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wr_data(mem_wr_data), .mem_rd_data(mem_rd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .done(done), .mismatch_err(mismatch_err)
  );
endmodule

// File: rtl/msg_dma_checker.sv
module msg_dma_checker
  import mpe_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              done,
  input logic              ovf_err,
  input logic              mismatch_err
);
  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  a_r11_no_rd_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  a_r11_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en && !tx_valid);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
  a_r8_mism_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_err |=> mismatch_err);
  a_r6_wr_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> rx_valid && rx_ready);
endmodule

bind msg_dma_engine msg_dma_checker u_chk (.*);

// File: tb/tb_msg_dma_engine.sv
`timescale 1ns/1ps
module tb_msg_dma_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, cmd_is_recv = 0, cmd_quiet = 0;
  logic [31:0] cmd_data = '0;
  logic mem_rd_en, mem_wr_en;
  logic [15:0] mem_addr;
  logic [31:0] mem_wr_data, mem_rd_data = '0;
  logic tx_valid, tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic rx_valid = 1'b0, rx_ready;
  logic [31:0] rx_data = '0;
  logic done, ovf_err, mismatch_err;

  msg_dma_engine dut (.*);

  always #2 clk = ~clk;

  int vectors = 0, miscompares = 0, done_cnt = 0, exp_done = 0, cyc = 0;
  bit stall_all = 0, rx_fire = 0;
  logic [31:0] exp_tx[$];
  logic [47:0] exp_wr[$];
  logic [31:0] rx_q[$];
  logic [31:0] mem [256];

  function automatic logic [31:0] init_val(int a);
    return 32'hC0DE_0000 + 32'(a) * 32'h0001_0011;
  endfunction

  initial for (int i = 0; i < 256; i++) mem[i] = init_val(i);

  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr[7:0]] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= mem[mem_addr[7:0]];
  end

  task automatic check(bit ok, string req, string what, logic [47:0] act, logic [47:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor / stream driver, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      tx_ready = !stall_all && (cyc % 3 != 0);
      if (rx_fire) void'(rx_q.pop_front());
      rx_valid = (rx_q.size() > 0);
      rx_data  = rx_valid ? rx_q[0] : 32'h0;
      rx_fire  = rx_valid && rx_ready;
      #1;
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) check(0, "R2", "unexpected tx beat", tx_data, 0);
        else begin
          logic [31:0] e;
          e = exp_tx.pop_front();
          check(tx_data == e, "R2", "tx beat", tx_data, e);
        end
      end
      if (mem_wr_en) begin
        if (exp_wr.size() == 0) check(0, "R6", "unexpected write", {mem_addr, mem_wr_data}, 0);
        else begin
          logic [47:0] w;
          w = exp_wr.pop_front();
          check({mem_addr, mem_wr_data} == w, "R6", "memory write", {mem_addr, mem_wr_data}, w);
        end
      end
      if (done) done_cnt++;
    end
  end

  always @(posedge clk) if (cyc > 100000) begin
    miscompares++;
    $display("FAIL R4 watchdog: actual %0d expected %0d", cyc, 100000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  function automatic logic [31:0] hdr(int src, int dst, int tag, int len);
    return {8'(src), 8'(dst), 8'(tag), 8'(len)};
  endfunction

  // R1: four beats, flags with the last
  task automatic post(bit recv, bit quiet, int peer, int addr, int len, int tag);
    logic [31:0] w [4];
    w[0] = 32'(peer); w[1] = 32'(addr); w[2] = 32'(len); w[3] = 32'(tag);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cmd_wr = 1; cmd_data = w[i];
      cmd_is_recv = (i == 3) ? recv : 1'b0;
      cmd_quiet   = (i == 3) ? quiet : 1'b0;
    end
    @(negedge clk);
    cmd_wr = 0; cmd_is_recv = 0; cmd_quiet = 0;
  endtask

  task automatic expect_send(int peer, int addr, int len, int tag);
    exp_tx.push_back(hdr(1, peer, tag, len));
    for (int i = 0; i < len; i++) exp_tx.push_back(init_val(addr + i));
  endtask

  task automatic feed_packet(int src, int tag, int len, int addr, bit good);
    rx_q.push_back(hdr(src, 1, tag, len));
    for (int i = 0; i < len; i++) begin
      logic [31:0] d;
      d = 32'hBEEF_0000 + 32'(src * 256 + tag * 16 + i);
      rx_q.push_back(d);
      if (good) exp_wr.push_back({16'(addr + i), d});
    end
  endtask

  task automatic drain();
    while (exp_tx.size() != 0 || exp_wr.size() != 0 || rx_q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    check(tx_valid == 0 && rx_ready == 0 && done == 0, "R10", "reset outputs",
          {tx_valid, rx_ready, done}, 0);
    check(ovf_err == 0 && mismatch_err == 0, "R10", "reset flags", {ovf_err, mismatch_err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 R2 R5: send 3 words under irregular back-pressure
    expect_send(5, 'h10, 3, 'h21);
    post(0, 0, 5, 'h10, 3, 'h21);
    drain();
    check(exp_tx.size() == 0, "R2", "send drained", exp_tx.size(), 0);

    // R9: zero-count send
    expect_send(7, 'h30, 0, 'h22);
    post(0, 0, 7, 'h30, 0, 'h22);
    drain();
    check(done_cnt == 0, "R7", "send gives no done", done_cnt, 0);

    // R6 R7: matching receive
    post(1, 0, 3, 'h40, 4, 7);
    feed_packet(3, 7, 4, 'h40, 1); exp_done++;
    drain();
    check(done_cnt == exp_done, "R7", "receive done", done_cnt, exp_done);
    check(mismatch_err == 0, "R8", "no mismatch on good header", mismatch_err, 0);
    check(mem[8'h43] == 32'hBEEF_0000 + 32'(3 * 256 + 7 * 16 + 3), "R6", "last word stored",
          mem[8'h43], 32'hBEEF_0000 + 32'(3 * 256 + 7 * 16 + 3));

    // R7: quiet receive, then zero-count receive
    post(1, 1, 3, 'h50, 2, 8);
    feed_packet(3, 8, 2, 'h50, 1);
    drain();
    check(done_cnt == exp_done, "R7", "quiet receive silent", done_cnt, exp_done);
    post(1, 0, 4, 'h58, 0, 5);
    feed_packet(4, 5, 0, 'h58, 1); exp_done++;
    drain();
    check(done_cnt == exp_done, "R7", "zero-count receive done", done_cnt, exp_done);

    // R4: send, receive, send; the second send waits for the receive
    expect_send(4, 'h20, 2, 'h31);
    expect_send(4, 'h24, 1, 'h33);
    post(0, 0, 4, 'h20, 2, 'h31);
    post(1, 0, 6, 'h60, 2, 'h32);
    post(0, 0, 4, 'h24, 1, 'h33);
    while (exp_tx.size() > 2) @(negedge clk);
    repeat (30) @(negedge clk);
    check(exp_tx.size() == 2, "R4", "later send held behind receive", exp_tx.size(), 2);
    feed_packet(6, 'h32, 2, 'h60, 1); exp_done++;
    drain();
    check(exp_tx.size() == 0 && done_cnt == exp_done, "R4", "ordered completion", done_cnt, exp_done);

    // R8: wrong tag packet discarded, then the right one lands
    post(1, 0, 2, 'h80, 2, 9);
    feed_packet(2, 'h0A, 3, 'h80, 0);
    feed_packet(2, 9, 2, 'h80, 1); exp_done++;
    drain();
    check(mismatch_err == 1, "R8", "mismatch flag", mismatch_err, 1);
    check(done_cnt == exp_done, "R8", "receive completes after discard", done_cnt, exp_done);

    // R3: fill the queue with the stream stalled
    check(ovf_err == 0, "R3", "no overflow yet", ovf_err, 0);
    stall_all = 1;
    for (int i = 0; i < 10; i++) begin
      if (i < 9) expect_send(9, 0, 0, 'h80 + i);
      post(0, 0, 9, 0, 0, 'h80 + i);
    end
    check(ovf_err == 1, "R3", "overflow flag", ovf_err, 1);
    stall_all = 0;
    drain();
    check(exp_tx.size() == 0, "R3", "nine queued headers out", exp_tx.size(), 0);
    check(ovf_err == 1 && mismatch_err == 1, "R3", "flags sticky", {ovf_err, mismatch_err}, 2'b11);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule